// File: doc/BRIEF.md
# Multi-register load sequencer

This block moves a run of consecutive 16-bit memory words into a 16-entry register file. The file holds eight data registers and eight address registers. A 16-bit selection mask picks the registers. A size flag chooses between full 32-bit loads, which take two word reads per register, and sign-extended 16-bit loads, which take one word read per register. A start pulse also carries a 3-bit addressing mode, a 3-bit base register number and two candidate start addresses. The first candidate is the present value of the base address register. The second is an already computed effective address.

Reads go out one word at a time over a request/acknowledge handshake. Each finished register is written through a single register-file write port. After the last selected register, the sequencer always fetches one more word and throws it away. In postincrement mode it then writes the final address back into the base address register, and this write wins over any value that was loaded into that register from memory. A one-cycle done pulse closes the operation.

Top module: `mreg_load_seq`

## Requirements
- R1: Mask bit k selects register-file index k (bits 0..7 are data registers 0..7 at indices 0..7, bits 8..15 are address registers 0..7 at indices 8..15), and selected registers are written in strictly ascending index order.
- R2: With long_i=1, each selected register takes two reads: the first at the current address supplies bits 31:16, and the second at address+2 supplies bits 15:0. The next register starts 4 bytes on.
- R3: With long_i=0, each selected register takes one read, and the next register starts 2 bytes on.
- R4: After the last selected register, exactly one more read is issued at the following address. Its data reaches no register.
- R5: With long_i=0, every written register, data registers included, has bits 31:16 equal to sixteen copies of bit 15 of the word read.
- R6: When mode_i equals 3, one extra write follows the discarded read. It goes to index 8+base_i with the address of that discarded read, and it comes after any load of the same index.
- R7: The start address is base_val_i when mode_i is 0..4 and ea_i when mode_i is 5..7.
- R8: While rd_req_o is high without rd_ack_i, the next cycle still has rd_req_o high with the same rd_addr_o. A read completes on a clock edge where both are high.
- R9: The number of register loads equals the population count of the mask. An all-zero mask performs only the discarded read.
- R10: done_o is a single-cycle pulse after the discarded read and any write-back, and start_i is ignored while busy_o is high. After reset the block is idle, with no request, write or done.
- R11: Addresses wrap modulo 2^32, and bit 0 of every issued address equals bit 0 of the start address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation (taken only when idle) |
| mask_i | input | 16 | Register selection, bit k = register-file index k |
| long_i | input | 1 | 1: 32-bit loads, 0: sign-extended 16-bit loads |
| mode_i | input | 3 | Addressing mode; 3 = postincrement |
| base_i | input | 3 | Base address register number |
| base_val_i | input | 32 | Current value of the base address register |
| ea_i | input | 32 | Precomputed start address for modes 5..7 |
| rd_req_o | output | 1 | Memory word read request |
| rd_addr_o | output | 32 | Byte address of the word read |
| rd_ack_i | input | 1 | Read completes on this cycle's edge |
| rd_data_i | input | 16 | Read data, valid with rd_ack_i |
| rf_we_o | output | 1 | Register-file write strobe |
| rf_idx_o | output | 4 | Register-file write index |
| rf_wdata_o | output | 32 | Register-file write data |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench sweeps every single-bit mask in both sizes. These runs separate the index mapping, the half ordering of long loads and the address step of each size. Pseudo-random masks across all eight modes and base numbers test ordering and population count on dense patterns, and the choice between the two start-address sources. An all-zero mask, a full mask in postincrement mode with the base register selected, a start address near 2^32 and an odd start address isolate the discarded read, the write-back override and the address wrap and bit-0 rules. A second start pulse in mid-operation with different inputs shows whether busy commands leak in. The memory answers after 0, 1 or 2 wait cycles in rotation, which exercises the handshake hold.

// File: rtl/mreg_load_pkg.sv
package mreg_load_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_READ = 3'd1,
    ST_TAIL = 3'd2,
    ST_WBACK = 3'd3,
    ST_FIN = 3'd4
  } seq_state_t;

  localparam logic [2:0] MODE_POSTINC = 3'd3;
  localparam logic [2:0] MODE_BASE_MAX = 3'd4;

endpackage

// File: rtl/mreg_mask_scan.sv
module mreg_mask_scan #(
  parameter int N = 16,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  mask_i,
  output logic          any_o,
  output logic [N-1:0]  low_o,
  output logic [IW-1:0] idx_o
);

  function automatic logic [N-1:0] column_sel(input int b);
    logic [N-1:0] m;
    for (int i = 0; i < N; i++) m[i] = ((i >> b) & 1) == 1;
    return m;
  endfunction

  assign any_o = |mask_i;
  assign low_o = mask_i & (~mask_i + N'(1));

  for (genvar b = 0; b < IW; b++) begin : g_idx
    localparam logic [N-1:0] SEL = column_sel(b);
    assign idx_o[b] = |(low_o & SEL);
  end

  always_comb begin
    AST_SCAN_LOWEST: assert ($onehot0(low_o) && ((low_o == '0) == (mask_i == '0))); // R1
  end

endmodule

// File: rtl/mreg_addr_gen.sv
module mreg_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int STEP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              adv_i,
  output logic [ADDR_W-1:0] addr_o
);

  function automatic logic [ADDR_W-1:0] advance(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(STEP);
  endfunction

  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else if (load_i) addr_q <= load_val_i;
    else if (adv_i) addr_q <= advance(addr_q);
  end

  assign addr_o = addr_q;

endmodule

// File: rtl/mreg_word_join.sv
module mreg_word_join #(
  parameter int WORD_W = 16,
  localparam int REG_W = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_hi_i,
  input  logic              long_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [REG_W-1:0]  result_o
);

  function automatic logic [REG_W-1:0] widen_signed(input logic [WORD_W-1:0] w);
    return {{WORD_W{w[WORD_W-1]}}, w};
  endfunction

  logic [WORD_W-1:0] hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_q <= '0;
    else if (cap_hi_i) hi_q <= word_i;
  end

  assign result_o = long_i ? {hi_q, word_i} : widen_signed(word_i);

  always_comb begin
    if (!long_i) begin
      AST_WORD_SEXT: assert (result_o[REG_W-1:WORD_W] == {WORD_W{result_o[WORD_W-1]}}); // R5
    end
  end

endmodule

// File: rtl/mreg_load_seq.sv
module mreg_load_seq
  import mreg_load_pkg::*;
#(
  parameter int NREG = 16,
  parameter int ADDR_W = 32,
  parameter int WORD_W = 16,
  localparam int IDX_W = $clog2(NREG),
  localparam int BASE_W = IDX_W - 1,
  localparam int REG_W = 2 * WORD_W,
  localparam int WORD_BYTES = WORD_W / 8,
  localparam int CNT_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [NREG-1:0]   mask_i,
  input  logic              long_i,
  input  logic [2:0]        mode_i,
  input  logic [BASE_W-1:0] base_i,
  input  logic [ADDR_W-1:0] base_val_i,
  input  logic [ADDR_W-1:0] ea_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_ack_i,
  input  logic [WORD_W-1:0] rd_data_i,
  output logic              rf_we_o,
  output logic [IDX_W-1:0]  rf_idx_o,
  output logic [REG_W-1:0]  rf_wdata_o,
  output logic              busy_o,
  output logic              done_o
);

  function automatic logic [CNT_W-1:0] pop_count(input logic [NREG-1:0] m);
    logic [CNT_W-1:0] c;
    c = '0;
    for (int i = 0; i < NREG; i++) c = c + CNT_W'(m[i]);
    return c;
  endfunction

  function automatic logic [ADDR_W-1:0] pick_start(input logic [2:0] md,
                                                   input logic [ADDR_W-1:0] bv,
                                                   input logic [ADDR_W-1:0] ea);
    return (md <= MODE_BASE_MAX) ? bv : ea;
  endfunction

  seq_state_t        state_q;
  logic [NREG-1:0]   mask_q;
  logic              long_q;
  logic [2:0]        mode_q;
  logic [BASE_W-1:0] base_q;
  logic              half_q;

  // named internal events
  logic              accept;
  logic              word_done;
  logic              reg_done;
  logic              cap_hi;
  logic              tail_done;
  logic              in_wback;

  logic              scan_any;
  logic [NREG-1:0]   scan_low;
  logic [IDX_W-1:0]  scan_idx;
  logic [NREG-1:0]   mask_next;
  logic [ADDR_W-1:0] addr;
  logic [REG_W-1:0]  joined;

  assign accept    = (state_q == ST_IDLE) && start_i;
  assign word_done = (state_q == ST_READ) && rd_ack_i;
  assign reg_done  = word_done && (!long_q || half_q);
  assign cap_hi    = word_done && long_q && !half_q;
  assign tail_done = (state_q == ST_TAIL) && rd_ack_i;
  assign in_wback  = (state_q == ST_WBACK);
  assign mask_next = mask_q & ~scan_low;

  mreg_mask_scan #(.N(NREG)) u_scan (
    .mask_i (mask_q),
    .any_o  (scan_any),
    .low_o  (scan_low),
    .idx_o  (scan_idx)
  );

  mreg_addr_gen #(.ADDR_W(ADDR_W), .STEP(WORD_BYTES)) u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (accept),
    .load_val_i (pick_start(mode_i, base_val_i, ea_i)),
    .adv_i      (word_done),
    .addr_o     (addr)
  );

  mreg_word_join #(.WORD_W(WORD_W)) u_join (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_hi_i (cap_hi),
    .long_i   (long_q),
    .word_i   (rd_data_i),
    .result_o (joined)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mask_q  <= '0;
      long_q  <= 1'b0;
      mode_q  <= '0;
      base_q  <= '0;
      half_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            mask_q  <= mask_i;
            long_q  <= long_i;
            mode_q  <= mode_i;
            base_q  <= base_i;
            half_q  <= 1'b0;
            state_q <= (|mask_i) ? ST_READ : ST_TAIL;
          end
        end
        ST_READ: begin
          if (cap_hi) begin
            half_q <= 1'b1;
          end else if (reg_done) begin
            half_q  <= 1'b0;
            mask_q  <= mask_next;
            state_q <= (|mask_next) ? ST_READ : ST_TAIL;
          end
        end
        ST_TAIL: begin
          if (rd_ack_i) state_q <= (mode_q == MODE_POSTINC) ? ST_WBACK : ST_FIN;
        end
        ST_WBACK: state_q <= ST_FIN;
        ST_FIN:   state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_req_o   = (state_q == ST_READ) || (state_q == ST_TAIL);
  assign rd_addr_o  = addr;
  assign rf_we_o    = reg_done || in_wback;
  assign rf_idx_o   = in_wback ? {1'b1, base_q} : scan_idx;
  assign rf_wdata_o = in_wback ? addr : joined;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = (state_q == ST_FIN);

  // checker state, kept apart from the datapath
  logic [CNT_W-1:0] chk_want_q;
  logic [CNT_W-1:0] chk_got_q;
  logic             chk_bit0_q;
  logic             chk_seen_q;
  logic [IDX_W-1:0] chk_last_q;
  logic             chk_tail_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_want_q <= '0;
      chk_got_q  <= '0;
      chk_bit0_q <= 1'b0;
      chk_seen_q <= 1'b0;
      chk_last_q <= '0;
      chk_tail_q <= 1'b0;
    end else if (accept) begin
      chk_want_q <= pop_count(mask_i);
      chk_got_q  <= '0;
      chk_bit0_q <= pick_start(mode_i, base_val_i, ea_i)[0];
      chk_seen_q <= 1'b0;
      chk_tail_q <= 1'b0;
    end else begin
      if (reg_done) begin
        chk_got_q  <= chk_got_q + CNT_W'(1);
        chk_seen_q <= 1'b1;
        chk_last_q <= scan_idx;
      end
      if (tail_done) chk_tail_q <= 1'b1;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && !rd_ack_i) |=> (rd_req_o && $stable(rd_addr_o))); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R10

  AST_DONE_AFTER_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> chk_tail_q); // R10

  AST_LOAD_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TAIL) |-> (chk_got_q == chk_want_q)); // R9

  AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_done && chk_seen_q) |-> (scan_idx > chk_last_q)); // R1

  AST_ADDR_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |-> (rd_addr_o[0] == chk_bit0_q)); // R11

  AST_TAIL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TAIL) |-> !rf_we_o); // R4

  AST_WBACK_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    in_wback |-> (chk_tail_q && mode_q == MODE_POSTINC)); // R6

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> ($stable(mode_q) && $stable(long_q) && $stable(base_q))); // R10

endmodule

// File: tb/mreg_load_seq_tb.sv
module mreg_load_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] mask_i = '0;
  logic        long_i = 1'b0;
  logic [2:0]  mode_i = '0;
  logic [2:0]  base_i = '0;
  logic [31:0] base_val_i = '0;
  logic [31:0] ea_i = '0;
  logic        rd_req_o;
  logic [31:0] rd_addr_o;
  logic        rd_ack_i = 1'b0;
  logic [15:0] rd_data_i = '0;
  logic        rf_we_o;
  logic [3:0]  rf_idx_o;
  logic [31:0] rf_wdata_o;
  logic        busy_o;
  logic        done_o;

  mreg_load_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mask_i(mask_i), .long_i(long_i),
    .mode_i(mode_i), .base_i(base_i), .base_val_i(base_val_i), .ea_i(ea_i),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i),
    .rf_we_o(rf_we_o), .rf_idx_o(rf_idx_o), .rf_wdata_o(rf_wdata_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  always #5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;

  // observed logs
  logic [31:0] rd_log [0:63];
  logic [3:0]  wi_log [0:31];
  logic [31:0] wd_log [0:31];
  int rd_n = 0, wr_n = 0, done_n = 0, done_wr = -1;
  int hold_bad = 0;
  // expected lists
  logic [31:0] ex_rd [0:63];
  logic [3:0]  ex_wi [0:31];
  logic [31:0] ex_wd [0:31];
  int ex_rd_n = 0, ex_wr_n = 0;

  int wait_cnt = 0, want_wait = 0, ack_n = 0;
  logic        prev_wait = 1'b0;
  logic [31:0] prev_addr = '0;

  function automatic logic [15:0] mem_word(input logic [31:0] a);
    return a[16:1] ^ 16'h9C35 ^ {a[31:28], 12'h0};
  endfunction

  function automatic logic [31:0] widen(input logic [15:0] w);
    if (w >= 16'h8000) return 32'hFFFF_0000 | {16'h0, w};
    return {16'h0, w};
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // memory responder and observer
  always @(negedge clk) begin
    cycles++;
    if (rd_req_o) begin
      if (wait_cnt >= want_wait) begin
        rd_ack_i  = 1'b1;
        rd_data_i = mem_word(rd_addr_o);
        wait_cnt  = 0;
        ack_n++;
        want_wait = ack_n % 3;
      end else begin
        rd_ack_i = 1'b0;
        wait_cnt++;
      end
    end else begin
      rd_ack_i = 1'b0;
    end
    #1;
    if (prev_wait && (!rd_req_o || rd_addr_o != prev_addr)) hold_bad++;
    prev_wait = rd_req_o && !rd_ack_i;
    prev_addr = rd_addr_o;
    if (rd_req_o && rd_ack_i && rd_n < 64) begin
      rd_log[rd_n] = rd_addr_o;
      rd_n++;
    end
    if (rf_we_o && wr_n < 32) begin
      wi_log[wr_n] = rf_idx_o;
      wd_log[wr_n] = rf_wdata_o;
      wr_n++;
    end
    if (done_o) begin
      done_n++;
      done_wr = wr_n;
    end
  end

  task automatic build_expect(input logic [15:0] mk, input logic lg, input logic [2:0] md,
                              input logic [2:0] bs, input logic [31:0] bv, input logic [31:0] ea);
    logic [31:0] a;
    a = (md < 3'd5) ? bv : ea;
    ex_rd_n = 0;
    ex_wr_n = 0;
    for (int i = 0; i < 16; i++) begin
      if (mk[i]) begin
        if (lg) begin
          ex_rd[ex_rd_n] = a; ex_rd[ex_rd_n+1] = a + 32'd2; ex_rd_n += 2;
          ex_wi[ex_wr_n] = 4'(i);
          ex_wd[ex_wr_n] = {mem_word(a), mem_word(a + 32'd2)};
          a = a + 32'd4;
        end else begin
          ex_rd[ex_rd_n] = a; ex_rd_n++;
          ex_wi[ex_wr_n] = 4'(i);
          ex_wd[ex_wr_n] = widen(mem_word(a));
          a = a + 32'd2;
        end
        ex_wr_n++;
      end
    end
    ex_rd[ex_rd_n] = a; ex_rd_n++;
    if (md == 3'd3) begin
      ex_wi[ex_wr_n] = 4'd8 + {1'b0, bs};
      ex_wd[ex_wr_n] = a;
      ex_wr_n++;
    end
  endtask

  task automatic run_op(input logic [15:0] mk, input logic lg, input logic [2:0] md,
                        input logic [2:0] bs, input logic [31:0] bv, input logic [31:0] ea,
                        input bit poke, input string tag);
    int cnt;
    int bad_at;
    build_expect(mk, lg, md, bs, bv, ea);
    @(negedge clk);
    rd_n = 0; wr_n = 0; done_n = 0; done_wr = -1; hold_bad = 0;
    start_i = 1'b1; mask_i = mk; long_i = lg; mode_i = md; base_i = bs;
    base_val_i = bv; ea_i = ea;
    @(negedge clk);
    start_i = 1'b0;
    if (poke) begin
      @(negedge clk);
      start_i = 1'b1; mask_i = ~mk; long_i = ~lg; mode_i = 3'd3; base_i = ~bs;
      base_val_i = ~bv; ea_i = ~ea;
      @(negedge clk);
      start_i = 1'b0;
    end
    cnt = 0;
    while (done_n == 0 && cnt < 3000) begin
      @(negedge clk);
      cnt++;
    end
    repeat (3) @(negedge clk);
    // read sequence
    bad_at = -1;
    for (int i = 0; i < ex_rd_n && i < rd_n; i++)
      if (bad_at < 0 && rd_log[i] != ex_rd[i]) bad_at = i;
    chk(rd_n == ex_rd_n, tag, "read count", rd_n, ex_rd_n);
    if (bad_at >= 0) chk(1'b0, tag, $sformatf("read addr #%0d", bad_at), rd_log[bad_at], ex_rd[bad_at]);
    else chk(1'b1, tag, "read addrs", 0, 0);
    // write sequence
    bad_at = -1;
    for (int i = 0; i < ex_wr_n && i < wr_n; i++)
      if (bad_at < 0 && (wi_log[i] != ex_wi[i] || wd_log[i] != ex_wd[i])) bad_at = i;
    chk(wr_n == ex_wr_n, tag, "write count", wr_n, ex_wr_n);
    if (bad_at >= 0) begin
      chk(wi_log[bad_at] == ex_wi[bad_at], tag, $sformatf("write idx #%0d", bad_at), wi_log[bad_at], ex_wi[bad_at]);
      chk(wd_log[bad_at] == ex_wd[bad_at], tag, $sformatf("write data #%0d", bad_at), wd_log[bad_at], ex_wd[bad_at]);
    end else chk(1'b1, tag, "write contents", 0, 0);
    chk(done_n == 1, tag, "R10 done pulse count", done_n, 1);
    chk(done_wr == ex_wr_n, tag, "R10 writes before done", done_wr, ex_wr_n);
    chk(hold_bad == 0, tag, "R8 request hold", hold_bad, 0);
    chk(!busy_o, tag, "R10 idle after done", busy_o, 0);
  endtask

  initial begin : watchdog
    wait (cycles > 150000);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    logic [31:0] rs;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !rd_req_o && !rf_we_o && !done_o, "R10", "reset idle", {busy_o, rd_req_o, rf_we_o, done_o}, 0);

    // single-bit sweep: index mapping, halves, step
    for (int lg = 0; lg < 2; lg++)
      for (int b = 0; b < 16; b++)
        run_op(16'(1 << b), lg[0], 3'd2, 3'(b), 32'h0000_1000 + 32'(b * 16), 32'hDEAD_0000, 1'b0,
               lg ? "R1/R2" : "R1/R3/R5");

    // empty mask: only the discarded read
    run_op(16'h0000, 1'b0, 3'd2, 3'd1, 32'h0000_4000, 32'h0, 1'b0, "R9/R4");
    run_op(16'h0000, 1'b1, 3'd3, 3'd2, 32'h0000_4100, 32'h0, 1'b0, "R9/R6");
    // full mask postincrement, base register also loaded
    run_op(16'hFFFF, 1'b1, 3'd3, 3'd5, 32'h0000_2000, 32'h0, 1'b0, "R6");
    run_op(16'h2F01, 1'b0, 3'd3, 3'd5, 32'h0000_8FF0, 32'h0, 1'b0, "R6/R5");
    // effective-address source
    run_op(16'h0F0F, 1'b1, 3'd5, 3'd0, 32'h1111_0000, 32'h0000_6000, 1'b0, "R7");
    run_op(16'h00F0, 1'b0, 3'd7, 3'd4, 32'h2222_0000, 32'h0000_7F00, 1'b0, "R7");
    run_op(16'h8001, 1'b1, 3'd4, 3'd4, 32'h0000_5000, 32'h3333_0000, 1'b0, "R7");
    // wrap and odd start
    run_op(16'h0003, 1'b1, 3'd3, 3'd0, 32'hFFFF_FFFA, 32'h0, 1'b0, "R11");
    run_op(16'h00FF, 1'b0, 3'd6, 3'd0, 32'h0, 32'hFFFF_FFF1, 1'b0, "R11");
    run_op(16'h0505, 1'b1, 3'd2, 3'd0, 32'h0000_0101, 32'h0, 1'b0, "R11");
    // start while busy
    run_op(16'hFFFF, 1'b0, 3'd2, 3'd1, 32'h0000_3000, 32'h0, 1'b1, "R10");
    run_op(16'hFFFF, 1'b1, 3'd6, 3'd6, 32'h0, 32'h0000_3800, 1'b1, "R10");

    // pseudo-random dense sweep over modes and bases
    rs = 32'h1234_5678;
    for (int k = 0; k < 40; k++) begin
      rs = rs ^ (rs << 13); rs = rs ^ (rs >> 17); rs = rs ^ (rs << 5);
      run_op(rs[15:0], k[0], 3'(k), 3'(k / 8), {rs[31:16], 16'h0} | 32'h0001_0000,
             {rs[23:8], 8'h0, rs[7:0]}, 1'b0, "R1/R9");
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule